// File: doc/BRIEF.md
# EDID Register Read Controller

This block presents four 32-bit registers on a simple register bus and acts, at register level only, like the controller of a display data channel. Software picks a display pin and issues a read command. It then pulls the 128-byte display identification image out of the data register, four bytes at a time. No wire-level I2C signalling takes place. The image comes from an internal read-only table that is computed from its byte address. Each read of the data register fetches bytes, advances an internal byte pointer and, on the last chunk, moves the bus phase to idle or wait.

Two inputs, one bit per pin, tell the block whether a monitor is attached and whether that monitor is a packet-based (DP) sink. The image is served only for an attached non-DP monitor whose slave address is the standard identification address.

Register map (address `reg_addr`): 0 = pin select, 1 = command, 2 = status, 3 = data.

Top module: `edid_regctl`

## Requirements
- R1: After reset, status reads 0x0000_0006 (HW_READY and NAK set), the command and data registers read 0, and `wr_err` is 0.
- R2: Command layout: bit 0 = read, bits 7:1 = slave address, bits 15:8 = start index, bits 24:16 = byte total, bits 27:25 = cycle type, bit 30 = software-ready (always stored as 0), bit 31 = clear-interrupt. Cycle codes: 0 none, 1 wait, 3 indexed wait, 4 stop, 5 stop-after, 7 indexed stop-after.
- R3: Slave address 0x50 selects the image. Any other nonzero address leaves it unselected, so reads yield 0x00 bytes. Address 0 keeps an earlier selection.
- R4: Cycle bit 26 (the index flag) loads the byte pointer from bits 15:8. Otherwise the pointer starts at 0.
- R5: Cycle codes 1, 3, 5 and 7 set phase DATA and ACTIVE. Code 4 clears the transaction, sets phase IDLE and clears ACTIVE, but only if the previously stored cycle code was nonzero. The phase code 3 never appears.
- R6: With the read bit set and remaining = total − pointer > 0, a data read returns min(4, remaining) bytes, the first in bits 7:0. Higher byte lanes keep their last value. With remaining ≤ 0, or with the read bit clear, the last latched word is returned.
- R7: A data read with remaining ≤ 4 sets the phase to IDLE for cycle codes 5 and 7 and to WAIT for the others, then clears the transaction (selection, availability, pointer, total, cycle).
- R8: Status layout: bit 0 ACTIVE, bit 1 NAK, bit 2 HW_READY, bit 3 WAIT flag, bit 4 INT, bit 5 IN_USE, bits 7:6 phase (0 idle, 1 data, 2 wait). A status read returns the value before setting IN_USE. Writing 1 to bit 5 clears IN_USE, and all other bits ignore writes.
- R9: A pin select write (pin in bits 2:0) clears the transaction. For a pin of 1..NUM_PINS it also sets HW_READY and the WAIT flag, clears ACTIVE and sets the phase to IDLE. NAK is cleared and the image enabled only if that pin has a non-DP monitor; otherwise NAK is set. Pin 0 or an out-of-range pin changes no status bit.
- R10: A command write with bit 31 set, while the stored bit 31 is 0, clears INT and sets HW_READY. While the stored bit 31 is 1, a write with bit 31 set is ignored. A write with bit 31 clear resets status to HW_READY, plus NAK if no image is enabled, with phase IDLE.
- R11: A byte at pointer ≥ 128, or with no selected slave or no enabled image, reads as 0x00 and does not advance the pointer.
- R12: Writes to the data register change nothing and set the sticky `wr_err` flag.
- R13: Read data appears on `rd_data` in the cycle after the strobe and holds until the next read. When write and read strobes coincide, only the write takes effect.
- R14: The image byte at address a is (a·37 + 90) mod 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| monitor_present | input | NUM_PINS | Monitor attached, per pin |
| pin_is_dp | input | NUM_PINS | Attached monitor is packet-based, per pin |
| wr_err | output | 1 | Sticky flag for a data register write |

## Verification
Several read transactions are driven:
- An aligned non-indexed read separates byte packing from pointer handling.
- An indexed read with a count that is not a multiple of four shows that the upper lanes keep their old bytes.
- A three-byte wait-cycle read separates the WAIT ending from the IDLE ending.
- A read that starts at index 120 with a total past the image end shows that bytes past 128 read as zero without advancing the pointer.
- A zero-count command shows that the latched word is returned.

Directed sequences then tell apart:
- DP and absent monitors from a served pin.
- A nonzero wrong slave address from address zero.
- A stop after a real cycle from a stop after no cycle.
- The two edges of the clear-interrupt bit.

// File: rtl/edid_regctl_pkg.sv
package edid_regctl_pkg;

    localparam logic [1:0] RA_PORT = 2'd0;
    localparam logic [1:0] RA_CMD  = 2'd1;
    localparam logic [1:0] RA_STAT = 2'd2;
    localparam logic [1:0] RA_DATA = 2'd3;

    localparam int CB_READ    = 0;
    localparam int CB_IDXFLAG = 26;
    localparam int CB_SW_RDY  = 30;
    localparam int CB_CLR_INT = 31;

    localparam logic [2:0] CYC_NONE       = 3'd0;
    localparam logic [2:0] CYC_WAIT       = 3'd1;
    localparam logic [2:0] CYC_IDX_WAIT   = 3'd3;
    localparam logic [2:0] CYC_STOP       = 3'd4;
    localparam logic [2:0] CYC_STOP_AFTER = 3'd5;
    localparam logic [2:0] CYC_IDX_STOP   = 3'd7;

    localparam logic [6:0] EDID_SLAVE = 7'h50;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_WAIT = 2'd2
    } phase_e;

    typedef struct packed {
        logic       sel;
        logic       avail;
        logic [7:0] ptr;
        logic [8:0] total;
        logic [2:0] cyc;
    } txn_t;

    typedef struct packed {
        phase_e phase;
        logic   inuse;
        logic   intr;
        logic   waitf;
        logic   hwrdy;
        logic   nak;
        logic   active;
    } stat_t;

    typedef struct packed {
        logic [31:0] port;
        logic [31:0] cmd;
        stat_t       st;
        txn_t        tx;
        logic [31:0] data;
        logic [31:0] rdata;
        logic        werr;
    } regs_t;

    function automatic logic [31:0] pack_status(stat_t s);
        return {24'd0, s.phase, s.inuse, s.intr, s.waitf, s.hwrdy, s.nak, s.active};
    endfunction

endpackage

// File: rtl/edid_pin_decode.sv
module edid_pin_decode #(
    parameter int NUM_PINS = 4,
    parameter int PIN_W    = 3
) (
    input  logic [PIN_W-1:0]    pin,
    input  logic [NUM_PINS-1:0] present,
    input  logic [NUM_PINS-1:0] is_dp,
    output logic                pin_ok,
    output logic                edid_ok
);
    always_comb begin
        pin_ok  = 1'b0;
        edid_ok = 1'b0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (pin == PIN_W'(i + 1)) begin
                pin_ok  = 1'b1;
                edid_ok = present[i] & ~is_dp[i];
            end
        end
    end
endmodule

// File: rtl/edid_rom.sv
module edid_rom #(
    parameter int ROM_MUL = 37,
    parameter int ROM_ADD = 90
) (
    input  logic [7:0] addr,
    output logic [7:0] data
);
    localparam logic [7:0] MUL8 = 8'(ROM_MUL);
    localparam logic [7:0] ADD8 = 8'(ROM_ADD);

    assign data = addr * MUL8 + ADD8;
endmodule

// File: rtl/edid_lane_fetch.sv
module edid_lane_fetch #(
    parameter int LANES      = 4,
    parameter int EDID_BYTES = 128,
    parameter int ROM_MUL    = 37,
    parameter int ROM_ADD    = 90,
    localparam int CNT_W     = $clog2(LANES + 1)
) (
    input  logic [7:0]         ptr,
    input  logic [CNT_W-1:0]   nbytes,
    input  logic               enable,
    output logic [LANES*8-1:0] lane_bytes,
    output logic [CNT_W-1:0]   advance
);
    logic [LANES-1:0] lane_ok;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [8:0] addr_w;
        logic [7:0] rom_byte;

        assign addr_w = {1'b0, ptr} + 9'(g);

        edid_rom #(.ROM_MUL(ROM_MUL), .ROM_ADD(ROM_ADD)) u_rom (
            .addr(addr_w[7:0]),
            .data(rom_byte)
        );

        assign lane_ok[g] = enable && (g < int'(nbytes)) && (int'(addr_w) < EDID_BYTES);
        assign lane_bytes[g*8 +: 8] = lane_ok[g] ? rom_byte : 8'h00;
    end

    always_comb begin
        advance = '0;
        for (int i = 0; i < LANES; i++) begin
            advance = advance + CNT_W'(lane_ok[i]);
        end
    end
endmodule

// File: rtl/edid_regctl.sv
module edid_regctl
    import edid_regctl_pkg::*;
#(
    parameter int NUM_PINS   = 4,
    parameter int EDID_BYTES = 128,
    parameter int ROM_MUL    = 37,
    parameter int ROM_ADD    = 90
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          reg_addr,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [31:0]         wr_data,
    output logic [31:0]         rd_data,
    input  logic [NUM_PINS-1:0] monitor_present,
    input  logic [NUM_PINS-1:0] pin_is_dp,
    output logic                wr_err
);
    localparam int LANES = 4;
    localparam int CNT_W = $clog2(LANES + 1);

    regs_t q, d;

    logic signed [10:0]  remain;
    logic [CNT_W-1:0]    nbytes;
    logic [LANES*8-1:0]  lane_bytes;
    logic [CNT_W-1:0]    advance;
    logic                pin_ok, edid_ok;
    logic [31:0]         cmd_w;
    logic [31:0]         status_word_w;
    logic [31:0]         cmd_word_w;

    assign remain = signed'({2'b00, q.tx.total}) - signed'({3'b000, q.tx.ptr});
    assign nbytes = (remain >= 11'sd4) ? CNT_W'(LANES)
                  : (remain > 11'sd0) ? CNT_W'(remain) : '0;

    edid_pin_decode #(.NUM_PINS(NUM_PINS), .PIN_W(3)) u_pin (
        .pin(wr_data[2:0]),
        .present(monitor_present),
        .is_dp(pin_is_dp),
        .pin_ok(pin_ok),
        .edid_ok(edid_ok)
    );

    edid_lane_fetch #(
        .LANES(LANES), .EDID_BYTES(EDID_BYTES),
        .ROM_MUL(ROM_MUL), .ROM_ADD(ROM_ADD)
    ) u_fetch (
        .ptr(q.tx.ptr),
        .nbytes(nbytes),
        .enable(q.tx.sel & q.tx.avail),
        .lane_bytes(lane_bytes),
        .advance(advance)
    );

    always_comb begin
        d     = q;
        cmd_w = wr_data;
        cmd_w[CB_SW_RDY] = 1'b0;
        if (wr_en) begin
            unique case (reg_addr)
                RA_PORT: begin
                    d.port = wr_data;
                    d.tx   = '0;
                    if (pin_ok) begin
                        d.st.phase  = PH_IDLE;
                        d.st.active = 1'b0;
                        d.st.hwrdy  = 1'b1;
                        d.st.waitf  = 1'b1;
                        d.tx.avail  = edid_ok;
                        d.st.nak    = ~edid_ok;
                    end
                end
                RA_CMD: begin
                    if (q.cmd[CB_CLR_INT]) begin
                        if (!wr_data[CB_CLR_INT]) begin
                            d.cmd[CB_CLR_INT] = 1'b0;
                            d.st       = '0;
                            d.st.hwrdy = 1'b1;
                            d.st.nak   = ~q.tx.avail;
                        end
                    end else begin
                        if (cmd_w[CB_CLR_INT]) begin
                            d.st.intr  = 1'b0;
                            d.st.hwrdy = 1'b1;
                        end
                        d.tx.total = cmd_w[24:16];
                        if (cmd_w[7:1] == EDID_SLAVE) d.tx.sel = 1'b1;
                        if (cmd_w[CB_IDXFLAG]) d.tx.ptr = cmd_w[15:8];
                        d.tx.cyc = cmd_w[27:25];
                        case (cmd_w[27:25])
                            CYC_STOP: begin
                                if (q.cmd[27:25] != CYC_NONE) begin
                                    d.tx        = '0;
                                    d.st.phase  = PH_IDLE;
                                    d.st.active = 1'b0;
                                end
                            end
                            CYC_WAIT, CYC_IDX_WAIT, CYC_STOP_AFTER, CYC_IDX_STOP: begin
                                d.st.phase  = PH_DATA;
                                d.st.active = 1'b1;
                            end
                            default: ;
                        endcase
                        d.cmd = cmd_w;
                    end
                end
                RA_STAT: begin
                    if (wr_data[5]) d.st.inuse = 1'b0;
                end
                default: d.werr = 1'b1;
            endcase
        end else if (rd_en) begin
            unique case (reg_addr)
                RA_PORT: d.rdata = q.port;
                RA_CMD:  d.rdata = q.cmd;
                RA_STAT: begin
                    d.rdata    = pack_status(q.st);
                    d.st.inuse = 1'b1;
                end
                default: begin
                    d.rdata = q.data;
                    if (q.cmd[CB_READ] && remain > 11'sd0) begin
                        for (int i = 0; i < LANES; i++) begin
                            if (i < int'(nbytes)) d.data[8*i +: 8] = lane_bytes[8*i +: 8];
                        end
                        d.tx.ptr = q.tx.ptr + 8'(advance);
                        d.rdata  = d.data;
                        if (remain <= 11'sd4) begin
                            d.st.phase = (q.tx.cyc == CYC_STOP_AFTER || q.tx.cyc == CYC_IDX_STOP)
                                       ? PH_IDLE : PH_WAIT;
                            d.tx = '0;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.st.hwrdy <= 1'b1;
            q.st.nak   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rd_data       = q.rdata;
    assign wr_err        = q.werr;
    assign status_word_w = pack_status(q.st);
    assign cmd_word_w    = q.cmd;
endmodule

// File: rtl/edid_regctl_chk.sv
module edid_regctl_chk #(
    parameter int NUM_PINS = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  reg_addr,
    input logic        wr_en,
    input logic        rd_en,
    input logic [5:0]  wr_lo,
    input logic [31:0] rd_data,
    input logic        wr_err,
    input logic [31:0] status_word,
    input logic [31:0] cmd_word
);
    logic pin_in_range;
    assign pin_in_range = (wr_lo[2:0] != 3'd0) && (int'(wr_lo[2:0]) <= NUM_PINS);

    AST_INUSE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && reg_addr == 2'd2) |=> status_word[5]); // R8

    AST_INUSE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == 2'd2 && wr_lo[5]) |=> !status_word[5]); // R8

    AST_STATUS_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == 2'd2) |=> $stable(status_word[4:0]) && $stable(status_word[7:6])); // R8

    AST_SWRDY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_word[30]); // R2

    AST_DATA_WRITE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == 2'd3) |=> wr_err); // R12

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> wr_err); // R12

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R13

    AST_PORT_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == 2'd0 && pin_in_range)
        |=> (!status_word[0] && status_word[2] && status_word[3] && status_word[7:6] == 2'd0)); // R9

    AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[7:6] != 2'b11); // R5
endmodule

bind edid_regctl edid_regctl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .reg_addr(reg_addr),
    .wr_en(wr_en),
    .rd_en(rd_en),
    .wr_lo(wr_data[5:0]),
    .rd_data(rd_data),
    .wr_err(wr_err),
    .status_word(status_word_w),
    .cmd_word(cmd_word_w)
);

// File: tb/edid_regctl_tb.sv
`timescale 1ns/1ps
module edid_regctl_tb;
    localparam logic [1:0] A_PORT = 2'd0, A_CMD = 2'd1, A_STAT = 2'd2, A_DATA = 2'd3;

    typedef struct packed {
        logic [7:0] idx;
        logic [8:0] cnt;
        logic [2:0] cyc;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VEC [NV] = '{
        '{8'd0,   9'd8,   3'd5},
        '{8'd4,   9'd10,  3'd7},
        '{8'd0,   9'd3,   3'd1},
        '{8'd120, 9'd130, 3'd3},
        '{8'd16,  9'd0,   3'd7}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        wr_err;
    logic [3:0]  monitor_present = 4'b0011;
    logic [3:0]  pin_is_dp       = 4'b0010;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    logic [31:0] data_m = '0;
    logic [31:0] v, v0;

    always #4 clk = ~clk;

    edid_regctl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .monitor_present(monitor_present),
        .pin_is_dp(pin_is_dp), .wr_err(wr_err)
    );

    function automatic logic [7:0] rom_byte(int a);
        return 8'((a * 37 + 90) & 255);
    endfunction

    function automatic logic [31:0] mk_cmd(logic [6:0] sl, logic [7:0] idx, logic [8:0] cnt,
                                           logic [2:0] cyc, logic rdb);
        return {4'b0000, cyc, cnt, idx, sl, rdb};
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic bus_wr(logic [1:0] a, logic [31:0] val);
        @(negedge clk);
        reg_addr = a; wr_data = val; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(logic [1:0] a, output logic [31:0] val);
        @(negedge clk);
        reg_addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        val = rd_data;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 wr_err", {31'd0, wr_err}, 32'd0);
        bus_rd(A_STAT, v); chk("R1 status", v, 32'h06);
        bus_rd(A_CMD, v);  chk("R1 cmd", v, 32'h0);
        bus_rd(A_DATA, v); chk("R1 data", v, 32'h0);

        // R8 IN_USE behaviour
        bus_rd(A_STAT, v); chk("R8 in_use set", v, 32'h26);
        bus_wr(A_STAT, 32'hFFFF_FFFF);
        bus_rd(A_STAT, v); chk("R8 clear, others read-only", v, 32'h06);

        // Vector table: R4 R6 R7 R11 R14
        for (int k = 0; k < NV; k++) begin
            int p, rem, n, exph, guard;
            bus_wr(A_PORT, 32'd1);
            bus_wr(A_CMD, mk_cmd(7'h50, VEC[k].idx, VEC[k].cnt, VEC[k].cyc, 1'b1));
            p   = VEC[k].cyc[1] ? int'(VEC[k].idx) : 0;
            rem = int'(VEC[k].cnt) - p;
            if (rem <= 0) begin
                bus_rd(A_DATA, v); chk("R6 latched word when nothing remains", v, data_m);
                exph = 1;
            end else begin
                guard = 0;
                while (guard < 100) begin
                    guard++;
                    n = (rem > 4) ? 4 : rem;
                    for (int i = 0; i < n; i++) begin
                        if (p < 128) begin
                            data_m[8*i +: 8] = rom_byte(p);
                            p++;
                        end else begin
                            data_m[8*i +: 8] = 8'h00;
                        end
                    end
                    bus_rd(A_DATA, v);
                    chk("R6 R4 R11 R14 data word", v, data_m);
                    if (rem <= 4) break;
                    rem = int'(VEC[k].cnt) - p;
                end
                exph = (VEC[k].cyc == 3'd5 || VEC[k].cyc == 3'd7) ? 0 : 2;
            end
            bus_rd(A_STAT, v); chk("R7 R5 phase", {30'd0, v[7:6]}, exph);
        end

        // R9 pin select variants
        bus_wr(A_PORT, 32'd2);
        bus_rd(A_STAT, v); chk("R9 dp monitor", v & 32'hCF, 32'h0E);
        bus_wr(A_PORT, 32'd3);
        bus_rd(A_STAT, v); chk("R9 no monitor", v & 32'hCF, 32'h0E);
        bus_wr(A_PORT, 32'd1);
        bus_rd(A_STAT, v); chk("R9 served pin", v & 32'hCF, 32'h0C);
        bus_wr(A_CMD, mk_cmd(7'h50, 8'd0, 9'd8, 3'd7, 1'b1));
        bus_rd(A_STAT, v); chk("R5 data phase active", v & 32'hCF, 32'h4D);
        bus_wr(A_PORT, 32'd0);
        bus_rd(A_STAT, v); chk("R9 pin 0 leaves status", v & 32'hCF, 32'h4D);
        bus_rd(A_DATA, v); chk("R9 pin write clears transaction", v, data_m);

        // R5 stop handling
        bus_wr(A_CMD, mk_cmd(7'h00, 8'd0, 9'd0, 3'd4, 1'b0));
        bus_rd(A_STAT, v); chk("R5 stop after cycle", v & 32'hC1, 32'h00);
        bus_wr(A_PORT, 32'd1);
        bus_wr(A_CMD, mk_cmd(7'h50, 8'd0, 9'd4, 3'd1, 1'b1));
        bus_wr(A_CMD, mk_cmd(7'h00, 8'd0, 9'd0, 3'd0, 1'b1));
        bus_wr(A_CMD, mk_cmd(7'h00, 8'd0, 9'd0, 3'd4, 1'b1));
        bus_rd(A_STAT, v); chk("R5 stop after no-cycle ignored", v & 32'hC1, 32'h41);

        // R3 slave address
        bus_wr(A_PORT, 32'd1);
        bus_wr(A_CMD, mk_cmd(7'h51, 8'd0, 9'd4, 3'd5, 1'b1));
        data_m = 32'h0;
        bus_rd(A_DATA, v); chk("R3 wrong slave yields zeros", v, data_m);
        bus_wr(A_PORT, 32'd1);
        bus_wr(A_CMD, mk_cmd(7'h50, 8'd0, 9'd0, 3'd0, 1'b1));
        bus_wr(A_CMD, mk_cmd(7'h00, 8'd10, 9'd12, 3'd7, 1'b1));
        data_m[7:0]  = rom_byte(10);
        data_m[15:8] = rom_byte(11);
        bus_rd(A_DATA, v); chk("R3 address zero keeps selection", v, data_m);

        // R10 clear-interrupt bit
        bus_wr(A_PORT, 32'd3);
        bus_rd(A_STAT, v);
        bus_wr(A_CMD, 32'h8000_0000);
        bus_rd(A_CMD, v); chk("R10 clr bit stored", v, 32'h8000_0000);
        bus_wr(A_CMD, 32'h8200_0000);
        bus_rd(A_CMD, v); chk("R10 write while set ignored", v, 32'h8000_0000);
        bus_rd(A_STAT, v); chk("R10 ignored write keeps phase", v & 32'hC1, 32'h00);
        bus_wr(A_CMD, 32'h0000_0000);
        bus_rd(A_STAT, v); chk("R10 controller reset", v, 32'h06);
        bus_rd(A_CMD, v); chk("R10 clr bit cleared", v, 32'h0);

        // R2 software-ready stored as zero
        bus_wr(A_CMD, 32'h4000_0000);
        bus_rd(A_CMD, v); chk("R2 sw ready dropped", v, 32'h0);

        // R12 data write ignored
        bus_wr(A_DATA, 32'hDEAD_BEEF);
        chk("R12 wr_err set", {31'd0, wr_err}, 32'd1);
        bus_rd(A_DATA, v); chk("R12 R6 data unchanged, read bit clear", v, data_m);

        // R13 hold and write priority
        bus_rd(A_STAT, v0);
        repeat (3) @(negedge clk);
        chk("R13 read data holds", rd_data, v0);
        bus_wr(A_STAT, 32'h20);
        @(negedge clk);
        reg_addr = A_STAT; wr_data = 32'h0; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R13 read ignored with write", rd_data, v0);
        bus_rd(A_STAT, v); chk("R13 no in_use from ignored read", {31'd0, v[5]}, 32'd0);

        finish_run();
    end
endmodule